// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces one data-memory address per access strobe. It draws the address from a small bank of pointer registers. When a pointer is used, the block returns its current value and then writes back that value plus a chosen stride. Each pointer has its own length register. When the length is nonzero, the write-back wraps inside a circular window that starts at the pointer's value as last loaded. This lets software walk ring buffers with no bounds checks in the loop.

Software or a sequencer first fills the pointer, stride and length registers through one shared load port. It then issues access strobes that name a pointer and a stride. A processor core with dual operand fetch places two of these generators side by side, and each one yields an address in the same cycle. The memory itself lies outside this block.

Top module: `cbag_dag`

## Requirements
- R1: After synchronous reset, `addr_vld` is 0, `addr_out` is 0, and every pointer, base, stride and length register holds 0.
- R2: On a cycle with `acc_en` high, the next cycle shows `addr_vld` = 1 and `addr_out` equal to the selected pointer's value before the update. The address is registered with one cycle of latency.
- R3: With the pointer's length equal to 0, an access writes back pointer plus stride, modulo 2^AW (linear post-modify).
- R4: With length L nonzero, an updated pointer that would reach base+L or beyond has L subtracted from it. The base is the value written by the most recent pointer load.
- R5: With length L nonzero, an updated pointer that would fall below the base has L added to it. Combined with R4, the pointer stays at base + ((ptr - base + stride) mod L), taken modulo 2^AW, whenever |stride| < L.
- R6: A stride register is a signed AW-bit two's complement value, so negative strides move the pointer downward.
- R7: When a pointer load (`ld_kind` = 0) and an access hit the same pointer in the same cycle, the loaded value wins. The address output still shows the old value.
- R8: An access changes only the selected pointer. All other pointers keep their values.
- R9: In a cycle with no access, `addr_vld` goes to 0 on the next cycle and `addr_out` holds its last value.
- R10: `ld_kind` is encoded as 0 = pointer (also sets the base), 1 = stride, 2 = length. Code 3 changes no register.
- R11: Loading a length leaves the pointer and its base untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Register load strobe |
| ld_kind | input | 2 | Register class: 0 pointer, 1 stride, 2 length, 3 none |
| ld_idx | input | IW | Register index within the class |
| ld_data | input | AW | Value to load |
| acc_en | input | 1 | Access strobe |
| acc_ptr | input | PW | Pointer used by the access |
| acc_mod | input | MW | Stride register used by the access |
| addr_out | output | AW | Registered address (pre-update pointer value) |
| addr_vld | output | 1 | Address valid, one cycle after the strobe |

## Verification
The window property assumes three things about each access: the pointer already lies inside its window, the stride's magnitude is below the length, and no register load lands in the same cycle. The wrap does only one correction, so larger strides or a pointer that has been moved away from its window fall outside what the property covers. The sweeps stay within these assumptions. They reload the pointer before each new length and choose strides between -(L-1) and L-1. The load-priority and length-reload cases are run only with zero length, or with the pointer still inside the new window.

// File: rtl/cbag_pkg.sv
package cbag_pkg;
  typedef enum logic [1:0] {
    LD_PTR  = 2'd0,
    LD_MOD  = 2'd1,
    LD_LEN  = 2'd2,
    LD_NONE = 2'd3
  } ld_kind_e;
endpackage

// File: rtl/cbag_bank.sv
module cbag_bank #(
  parameter int AW   = 14,
  parameter int NPTR = 4,
  parameter int NMOD = 4,
  parameter int IW   = 2,
  localparam int PW  = $clog2(NPTR)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ld_en,
  input  logic [1:0]                 ld_kind,
  input  logic [IW-1:0]              ld_idx,
  input  logic [AW-1:0]              ld_data,
  input  logic                       upd_en,
  input  logic [PW-1:0]              upd_idx,
  input  logic [AW-1:0]              upd_val,
  output logic [NPTR-1:0][AW-1:0]    ptr_q,
  output logic [NPTR-1:0][AW-1:0]    base_q,
  output logic [NPTR-1:0][AW-1:0]    len_q,
  output logic [NMOD-1:0][AW-1:0]    mod_q
);
  import cbag_pkg::*;

  ld_kind_e kind;
  assign kind = ld_kind_e'(ld_kind);

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    logic hit_ptr, hit_len, hit_upd;
    assign hit_ptr = ld_en && (kind == LD_PTR) && (ld_idx == IW'(i));
    assign hit_len = ld_en && (kind == LD_LEN) && (ld_idx == IW'(i));
    assign hit_upd = upd_en && (upd_idx == PW'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        ptr_q[i]  <= '0;
        base_q[i] <= '0;
        len_q[i]  <= '0;
      end else begin
        if (hit_ptr) begin
          ptr_q[i]  <= ld_data;
          base_q[i] <= ld_data;
        end else if (hit_upd) begin
          ptr_q[i]  <= upd_val;
        end
        if (hit_len) len_q[i] <= ld_data;
      end
    end
  end

  for (genvar j = 0; j < NMOD; j++) begin : g_mod
    always_ff @(posedge clk) begin
      if (rst) mod_q[j] <= '0;
      else if (ld_en && (kind == LD_MOD) && (ld_idx == IW'(j))) mod_q[j] <= ld_data;
    end
  end
endmodule

// File: rtl/cbag_wrap.sv
module cbag_wrap #(
  parameter int AW = 14,
  localparam int EW = AW + 2
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  input  logic [AW-1:0] stride,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0]        rel;
  logic signed [EW-1:0] off, lens, adj;

  always_comb begin
    rel  = ptr - base;
    off  = $signed({2'b00, rel}) + $signed({{2{stride[AW-1]}}, stride});
    lens = $signed({2'b00, len});
    if (off >= lens)      adj = off - lens;
    else if (off < 0)     adj = off + lens;
    else                  adj = off;
    if (len == '0) nxt = ptr + stride;
    else           nxt = base + adj[AW-1:0];
  end
endmodule

// File: rtl/cbag_dag.sv
module cbag_dag #(
  parameter int AW   = 14,
  parameter int NPTR = 4,
  parameter int NMOD = 4,
  localparam int PW  = $clog2(NPTR),
  localparam int MW  = $clog2(NMOD),
  localparam int IW  = (PW > MW) ? PW : MW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [1:0]    ld_kind,
  input  logic [IW-1:0] ld_idx,
  input  logic [AW-1:0] ld_data,
  input  logic          acc_en,
  input  logic [PW-1:0] acc_ptr,
  input  logic [MW-1:0] acc_mod,
  output logic [AW-1:0] addr_out,
  output logic          addr_vld
);
  logic [NPTR-1:0][AW-1:0] ptr_q, base_q, len_q;
  logic [NMOD-1:0][AW-1:0] mod_q;
  logic [AW-1:0]           nxt;

  cbag_bank #(.AW(AW), .NPTR(NPTR), .NMOD(NMOD), .IW(IW)) u_bank (
    .clk(clk), .rst(rst),
    .ld_en(ld_en), .ld_kind(ld_kind), .ld_idx(ld_idx), .ld_data(ld_data),
    .upd_en(acc_en), .upd_idx(acc_ptr), .upd_val(nxt),
    .ptr_q(ptr_q), .base_q(base_q), .len_q(len_q), .mod_q(mod_q)
  );

  cbag_wrap #(.AW(AW)) u_wrap (
    .ptr(ptr_q[acc_ptr]), .base(base_q[acc_ptr]), .len(len_q[acc_ptr]),
    .stride(mod_q[acc_mod]), .nxt(nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_out <= '0;
      addr_vld <= 1'b0;
    end else begin
      addr_vld <= acc_en;
      if (acc_en) addr_out <= ptr_q[acc_ptr];
    end
  end
endmodule

// File: rtl/cbag_dag_chk.sv
module cbag_dag_chk #(
  parameter int AW   = 14,
  parameter int NPTR = 4,
  parameter int NMOD = 4,
  localparam int PW  = $clog2(NPTR),
  localparam int MW  = $clog2(NMOD),
  localparam int IW  = (PW > MW) ? PW : MW
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    ld_en,
  input logic [1:0]              ld_kind,
  input logic [IW-1:0]           ld_idx,
  input logic [AW-1:0]           ld_data,
  input logic                    acc_en,
  input logic [PW-1:0]           acc_ptr,
  input logic [MW-1:0]           acc_mod,
  input logic [AW-1:0]           addr_out,
  input logic                    addr_vld,
  input logic [NPTR-1:0][AW-1:0] ptr_q,
  input logic [NPTR-1:0][AW-1:0] base_q,
  input logic [NPTR-1:0][AW-1:0] len_q,
  input logic [NMOD-1:0][AW-1:0] mod_q
);
  logic [AW-1:0] p_sel, b_sel, l_sel, m_sel, m_abs, rel_sel;
  logic          win_ok, stride_ok, ptr_load_same;

  always_comb begin
    p_sel     = ptr_q[acc_ptr];
    b_sel     = base_q[acc_ptr];
    l_sel     = len_q[acc_ptr];
    m_sel     = mod_q[acc_mod];
    m_abs     = m_sel[AW-1] ? (~m_sel + 1'b1) : m_sel;
    rel_sel   = p_sel - b_sel;
    win_ok    = rel_sel < l_sel;
    stride_ok = m_abs < l_sel;
    ptr_load_same = ld_en && (ld_kind == 2'd0) && (ld_idx == IW'(acc_ptr));
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!addr_vld && addr_out == '0));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    acc_en |=> addr_vld);

  a_r2_addr_pre_update: assert property (@(posedge clk) disable iff (rst)
    acc_en |=> addr_out == $past(p_sel));

  a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !acc_en |=> (!addr_vld && $stable(addr_out)));

  a_r3_linear_step: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !ld_en && l_sel == '0) |=> ptr_q[$past(acc_ptr)] == $past(p_sel + m_sel));

  a_r5_stays_in_window: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !ld_en && l_sel != '0 && win_ok && stride_ok)
      |=> (ptr_q[$past(acc_ptr)] - base_q[$past(acc_ptr)]) < len_q[$past(acc_ptr)]);

  a_r7_load_wins: assert property (@(posedge clk) disable iff (rst)
    (acc_en && ptr_load_same) |=> ptr_q[$past(acc_ptr)] == $past(ld_data));

  for (genvar i = 0; i < NPTR; i++) begin : g_other
    a_r8_others_stable: assert property (@(posedge clk) disable iff (rst)
      (acc_en && acc_ptr != PW'(i) && !(ld_en && ld_kind == 2'd0 && ld_idx == IW'(i)))
        |=> $stable(ptr_q[i]));
  end
endmodule

bind cbag_dag cbag_dag_chk #(.AW(AW), .NPTR(NPTR), .NMOD(NMOD)) u_chk (.*);

// File: tb/sim_cbag_dag.sv
`timescale 1ns/1ps
module sim_cbag_dag;
  localparam int AW = 14;
  localparam int MASK = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst;
  logic          ld_en;
  logic [1:0]    ld_kind;
  logic [1:0]    ld_idx;
  logic [AW-1:0] ld_data;
  logic          acc_en;
  logic [1:0]    acc_ptr;
  logic [1:0]    acc_mod;
  logic [AW-1:0] addr_out;
  logic          addr_vld;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  int mptr[4], mbase[4], mlen[4], mmod[4];

  always #2 clk = ~clk;

  cbag_dag #(.AW(AW), .NPTR(4), .NMOD(4)) u0 (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_kind(ld_kind), .ld_idx(ld_idx),
    .ld_data(ld_data), .acc_en(acc_en), .acc_ptr(acc_ptr), .acc_mod(acc_mod),
    .addr_out(addr_out), .addr_vld(addr_vld)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sx(input int v);
    return (v >= (1 << (AW-1))) ? v - (1 << AW) : v;
  endfunction

  function automatic int step(input int p, input int b, input int l, input int m);
    int off;
    if (l == 0) return (p + sx(m)) & MASK;
    off = ((p - b) & MASK) + sx(m);
    off = ((off % l) + l) % l;
    return (b + off) & MASK;
  endfunction

  task automatic load(input int kind, input int idx, input int data);
    @(negedge clk);
    ld_en = 1'b1; ld_kind = kind[1:0]; ld_idx = idx[1:0]; ld_data = data[AW-1:0];
    @(negedge clk);
    ld_en = 1'b0;
    case (kind)
      0: begin mptr[idx] = data & MASK; mbase[idx] = data & MASK; end
      1: mmod[idx] = data & MASK;
      2: mlen[idx] = data & MASK;
      default: ;
    endcase
  endtask

  task automatic access(input string req, input int p, input int m);
    @(negedge clk);
    acc_en = 1'b1; acc_ptr = p[1:0]; acc_mod = m[1:0];
    @(negedge clk);
    acc_en = 1'b0;
    chk(req, int'(addr_vld), 1);
    chk(req, int'(addr_out), mptr[p]);
    mptr[p] = step(mptr[p], mbase[p], mlen[p], mmod[m]);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ld_en = 1'b0; ld_kind = '0; ld_idx = '0; ld_data = '0;
    acc_en = 1'b0; acc_ptr = '0; acc_mod = '0;
    for (int i = 0; i < 4; i++) begin mptr[i] = 0; mbase[i] = 0; mlen[i] = 0; mmod[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset outputs and zeroed registers
    chk("R1", int'(addr_vld), 0);
    chk("R1", int'(addr_out), 0);
    for (int i = 0; i < 4; i++) access("R1", i, i);
    // R9: idle cycle drops valid, holds address
    @(negedge clk);
    chk("R9", int'(addr_vld), 0);
    chk("R9", int'(addr_out), 0);

    // R3 and R6: linear post-modify, wrap at 2^AW, signed stride
    load(0, 0, 16380); load(1, 0, 7);
    for (int k = 0; k < 4; k++) access("R3", 0, 0);
    load(0, 1, 1); load(1, 1, (-3) & MASK);
    for (int k = 0; k < 4; k++) access("R6", 1, 1);
    for (int s = -5; s <= 5; s++) begin
      load(1, 2, s & MASK); load(0, 2, 40 + s);
      for (int k = 0; k < 3; k++) access("R3", 2, 2);
    end

    // R2, R4, R5: circular sweep over lengths, strides and two bases
    for (int bsel = 0; bsel < 2; bsel++) begin
      for (int L = 1; L <= 7; L++) begin
        for (int s = -(L-1); s <= L-1; s++) begin
          load(0, 3, (bsel == 0) ? 100 : 16381);
          load(2, 3, L);
          load(1, 3, s & MASK);
          for (int k = 0; k < 2*L; k++) access((s >= 0) ? "R4" : "R5", 3, 3);
        end
      end
    end

    // R2: back-to-back strobes
    load(2, 0, 0); load(0, 0, 10); load(1, 0, 2);
    @(negedge clk); acc_en = 1'b1; acc_ptr = 2'd0; acc_mod = 2'd0;
    @(negedge clk);
    chk("R2", int'(addr_vld), 1); chk("R2", int'(addr_out), 10);
    @(negedge clk); acc_en = 1'b0;
    chk("R2", int'(addr_vld), 1); chk("R2", int'(addr_out), 12);
    mptr[0] = 14;
    access("R2", 0, 0);

    // R7: pointer load and access on the same pointer
    load(2, 1, 0); load(0, 1, 300); load(1, 1, 5);
    @(negedge clk);
    acc_en = 1'b1; acc_ptr = 2'd1; acc_mod = 2'd1;
    ld_en = 1'b1; ld_kind = 2'd0; ld_idx = 2'd1; ld_data = 14'd500;
    @(negedge clk);
    acc_en = 1'b0; ld_en = 1'b0;
    chk("R7", int'(addr_out), 300);
    mptr[1] = 500; mbase[1] = 500;
    access("R7", 1, 1);

    // R8: repeated accesses on one pointer leave the others alone
    load(2, 2, 0); load(0, 2, 1000); load(2, 3, 0); load(0, 3, 2000);
    for (int k = 0; k < 6; k++) access("R8", 2, 1);
    access("R8", 3, 1);
    access("R8", 0, 1);

    // R10: kind code 3 has no effect
    load(0, 0, 77); load(1, 0, 1); load(2, 0, 0);
    load(3, 0, 999);
    access("R10", 0, 0);
    access("R10", 0, 0);

    // R11: length load keeps pointer and base
    load(0, 2, 200); load(1, 2, 1); load(2, 2, 0);
    access("R11", 2, 2);
    load(2, 2, 3);
    for (int k = 0; k < 5; k++) access("R11", 2, 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule